// File: doc/BRIEF.md
# Packed Fixed-Point Butterfly Unit

This block is a pipelined SIMD datapath for the butterfly step of fixed-point transforms such as DCT and FFT. Each 64-bit input word holds four signed 16-bit lanes. In every lane, the unit takes two data values `a` and `b` and one coefficient `c`. It computes both `(a+b)*c` and `(a-b)*c` at full precision, rounds each product half-up and shifts it right arithmetically by a shared shift amount. It then keeps the low 16 bits of each result.

All sum results are packed into one 64-bit output word and all difference results into a second word. The second word is meant for the register that follows the first destination. A shift of 14 matches coefficients held in 2.14 fixed point.

The pipeline takes a new operand set on every cycle and delivers results two clock edges later, marked by `out_valid`.

Top module: `pk_butterfly_top`

## Requirements
- R1: Lane i of every 64-bit operand and result occupies bits [16i+15:16i], for i = 0 to 3. Lanes are computed independently: a lane's result depends only on the same lane of `in_a`, `in_b` and `in_coef`.
- R2: Lane values are signed two's complement. The sum and the difference are kept to 17 bits before the multiply, so a = b = 0x7FFF with c = 1 and shift 1 gives 0x7FFF.
- R3: Each lane of `out_sum` equals the low 16 bits of floor((a+b)*c / 2^sh + 0.5) when sh is 1 to 16.
- R4: Each lane of `out_diff` equals the low 16 bits of floor((a-b)*c / 2^sh + 0.5), using the same c and sh as the sum.
- R5: A shift of 0 adds no rounding constant. Each result is then the low 16 bits of the full product.
- R6: A shift of 14 (2.14 coefficients) gives results that follow R3 and R4 exactly, including negative products and exact half values.
- R7: A shift value above 16 behaves exactly like a shift of 16.
- R8: Results wrap to 16 bits with no saturation. For example, a = b = c = 0x8000 with shift 14 gives a sum result of 0x0000.
- R9: An operand set accepted with `in_valid` at one rising edge appears on the outputs with `out_valid` high after the next rising edge. A new set can be accepted on every cycle, and `out_valid` is low when no set was accepted two edges earlier.
- R10: While `rst` is high, `out_valid`, `out_sum` and `out_diff` are all zero.
- R11: `out_sum` and `out_diff` hold their value while no new result is delivered, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present this cycle |
| in_a | input | 64 | Packed first data operands |
| in_b | input | 64 | Packed second data operands |
| in_coef | input | 64 | Packed coefficients |
| in_shift | input | 5 | Right-shift amount, 0 to 16 (larger values clamp to 16) |
| out_valid | output | 1 | Results present this cycle |
| out_sum | output | 64 | Packed rounded (a+b)*c results |
| out_diff | output | 64 | Packed rounded (a-b)*c results |

## Verification
The bench builds the unit with its default parameters: four lanes of 16 bits, a 5-bit shift field and a maximum shift of 16. Because the shift field can hold values up to 31, the clamp above 16 can be driven directly. With 16-bit lanes, the extreme products (full-scale positive and most-negative values) can be reached with a few vectors, so the 17-bit sum, the rounding at shifts 0, 1, 14 and 16, and the wrap at the lane boundary are all exercised. The per-lane reference model works on 64-bit integers, so each expected result is computed exactly.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    localparam int LANE_W = 16;
    localparam int SH_W   = 5;
    localparam int SH_MAX = 16;
    localparam int SUM_W  = LANE_W + 1;
    localparam int PROD_W = SUM_W + LANE_W + 1;

    // stage-one payload of one lane
    typedef struct packed {
        logic signed [SUM_W-1:0]  sum;
        logic signed [SUM_W-1:0]  dif;
        logic signed [LANE_W-1:0] coef;
    } lane_pre_t;

    // control travelling alongside the data
    typedef struct packed {
        logic            valid;
        logic [SH_W-1:0] sh;
    } ctl_t;

    function automatic logic [SH_W-1:0] clamp_shift(input logic [SH_W-1:0] raw);
        return (raw > SH_W'(SH_MAX)) ? SH_W'(SH_MAX) : raw;
    endfunction

    function automatic logic signed [PROD_W-1:0] round_shift(
        input logic signed [PROD_W-1:0] prod,
        input logic [SH_W-1:0]          sh
    );
        logic signed [PROD_W-1:0] bias;
        logic signed [PROD_W-1:0] acc;
        bias = '0;
        if (sh != '0) begin
            bias = PROD_W'(1) << (sh - SH_W'(1));
        end
        acc = prod + bias;
        return acc >>> sh;
    endfunction

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
    import bfly_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [SH_W-1:0] in_shift,
    output ctl_t            stage1,
    output logic            out_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1    <= '0;
            out_valid <= 1'b0;
        end else begin
            stage1.valid <= in_valid;
            if (in_valid) begin
                stage1.sh <= clamp_shift(in_shift);
            end
            out_valid <= stage1.valid;
        end
    end

    // the shift kept in the pipe never exceeds the maximum (R7)
    always_comb begin
        p_shift_clamped_r7: assert (rst || stage1.sh <= SH_W'(SH_MAX));
    end

endmodule

// File: rtl/bfly_lane.sv
module bfly_lane
    import bfly_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [LANE_W-1:0] c,
    input  ctl_t              stage1,
    output logic [LANE_W-1:0] res_sum,
    output logic [LANE_W-1:0] res_dif
);

    lane_pre_t pre_d, pre_q;
    logic signed [PROD_W-1:0] prod_sum, prod_dif;
    logic signed [PROD_W-1:0] rnd_sum, rnd_dif;

    // stage one: sign extend and form the 17-bit sum and difference
    always_comb begin
        pre_d.sum  = SUM_W'($signed(a)) + SUM_W'($signed(b));
        pre_d.dif  = SUM_W'($signed(a)) - SUM_W'($signed(b));
        pre_d.coef = $signed(c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (in_valid) begin
            pre_q <= pre_d;
        end
    end

    // stage two: shared-coefficient multiply, round, shift, wrap
    always_comb begin
        prod_sum = PROD_W'(pre_q.sum) * PROD_W'(pre_q.coef);
        prod_dif = PROD_W'(pre_q.dif) * PROD_W'(pre_q.coef);
        rnd_sum  = round_shift(prod_sum, stage1.sh);
        rnd_dif  = round_shift(prod_dif, stage1.sh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_sum <= '0;
            res_dif <= '0;
        end else if (stage1.valid) begin
            res_sum <= rnd_sum[LANE_W-1:0];
            res_dif <= rnd_dif[LANE_W-1:0];
        end
    end

    // a zero coefficient yields zero in both halves (R3, R4)
    p_zero_coef_r3: assert property (@(posedge clk) disable iff (rst)
        (stage1.valid && pre_q.coef == '0) |=> (res_sum == '0 && res_dif == '0));

    // equal operands give a zero difference result (R4)
    p_equal_ops_r4: assert property (@(posedge clk) disable iff (rst)
        (stage1.valid && pre_q.dif == '0) |=> (res_dif == '0));

endmodule

// File: rtl/pk_butterfly_top.sv
module pk_butterfly_top
    import bfly_pkg::*;
#(
    parameter int LANES = 4,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic [WORD_W-1:0] in_coef,
    input  logic [SH_W-1:0]   in_shift,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_sum,
    output logic [WORD_W-1:0] out_diff
);

    ctl_t stage1;

    bfly_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_shift  (in_shift),
        .stage1    (stage1),
        .out_valid (out_valid)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bfly_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .a        (in_a[i*LANE_W +: LANE_W]),
            .b        (in_b[i*LANE_W +: LANE_W]),
            .c        (in_coef[i*LANE_W +: LANE_W]),
            .stage1   (stage1),
            .res_sum  (out_sum[i*LANE_W +: LANE_W]),
            .res_dif  (out_diff[i*LANE_W +: LANE_W])
        );
    end

    // cycles since reset, saturating, so $past never reaches before reset
    logic [1:0] rst_age;
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_age <= '0;
        end else if (rst_age != 2'd3) begin
            rst_age <= rst_age + 2'd1;
        end
    end

    // two-edge latency, one result per accepted set (R9)
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (rst_age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // outputs hold between results (R11)
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_sum) && $stable(out_diff)));

    // reset state (R10)
    p_reset_r10: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_sum == '0 && out_diff == '0));

endmodule

// File: tb/tb_pk_butterfly_top.sv
module tb_pk_butterfly_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0, in_b = '0, in_coef = '0;
    logic [4:0]  in_shift = '0;
    logic        out_valid;
    logic [63:0] out_sum, out_diff;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    pk_butterfly_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_coef(in_coef), .in_shift(in_shift),
        .out_valid(out_valid), .out_sum(out_sum), .out_diff(out_diff)
    );

    function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b,
                                             input logic [15:0] c, input logic [4:0] sh,
                                             input bit dif);
        longint av = longint'($signed(a));
        longint bv = longint'($signed(b));
        longint cv = longint'($signed(c));
        longint s  = dif ? av - bv : av + bv;
        longint p  = s * cv;
        int     e  = (sh > 5'd16) ? 16 : int'(sh);
        longint r;
        if (e == 0) r = p;
        else        r = (p + (longint'(1) <<< (e - 1))) >>> e;
        return r[15:0];
    endfunction

    function automatic logic [63:0] ref_word(input logic [63:0] a, input logic [63:0] b,
                                             input logic [63:0] c, input logic [4:0] sh,
                                             input bit dif);
        logic [63:0] w;
        for (int i = 0; i < 4; i++) begin
            w[i*16 +: 16] = ref_lane(a[i*16 +: 16], b[i*16 +: 16], c[i*16 +: 16], sh, dif);
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one set, then sample two negedges later
    task automatic one_shot(input string req, input logic [63:0] a, input logic [63:0] b,
                            input logic [63:0] c, input logic [4:0] sh);
        @(negedge clk);
        in_a = a; in_b = b; in_coef = c; in_shift = sh; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_a = ~a; in_b = ~b; in_coef = ~c; in_shift = 5'd3;
        @(negedge clk);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " sum"},   out_sum,  ref_word(a, b, c, sh, 1'b0));
        check({req, " diff"},  out_diff, ref_word(a, b, c, sh, 1'b1));
        @(negedge clk);
        check({req, " R9 valid drops"}, 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R10 valid", 64'(out_valid), 64'd0);
        check("R10 sum",   out_sum,  64'd0);
        check("R10 diff",  out_diff, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_lanes;
        // only lane 2 nonzero: all other lanes of both results must be zero
        one_shot("R1 lane2", 64'h0000_0123_0000_0000, 64'h0000_0045_0000_0000,
                 64'h0000_0100_0000_0000, 5'd4);
        one_shot("R1 mixed", 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040,
                 64'h0003_0005_0007_0009, 5'd1);
    endtask

    task automatic t_precision;
        // 0x7FFF+0x7FFF needs 17 bits; result 0x7FFF in every lane
        one_shot("R2 full sum", {4{16'h7FFF}}, {4{16'h7FFF}}, {4{16'h0001}}, 5'd1);
        check("R2 literal", out_sum, {4{16'h7FFF}});
    endtask

    task automatic t_s14;
        one_shot("R3 R4 R6 s14", 64'h1111_E000_2400_C800, 64'h0F0F_F123_DCBA_3000,
                 {4{16'h2D41}}, 5'd14);
        // exact halves: -3*1>>1 -> -1, 3*1>>1 -> 2, -1>>1 -> 0, 1>>1 -> 1
        one_shot("R3 R4 half", 64'hFFFF_0001_0003_FFFD, 64'h0000_0000_0000_0000,
                 {4{16'h0001}}, 5'd1);
        check("R3 half literal", out_sum, 64'h0000_0001_0002_FFFF);
        one_shot("R3 s16", 64'h7FFF_8000_4000_C000, 64'h7FFF_8000_4001_BFFF,
                 64'h7FFF_8000_7FFF_8001, 5'd16);
    endtask

    task automatic t_sh0;
        one_shot("R5 sh0", 64'h1234_8765_0FF0_7F01, 64'h0101_0202_F00F_1234,
                 64'h0003_FFFF_0101_7777, 5'd0);
        check("R5 literal", out_sum[15:0], 16'(longint'(16'h7F01 + 16'h1234) * longint'(16'h7777)));
    endtask

    task automatic t_clamp;
        logic [63:0] s16, d16;
        one_shot("R7 sh16", 64'h7000_9000_1234_ABCD, 64'h6000_8800_4321_DCBA,
                 64'h7FFF_7FFF_8000_2222, 5'd16);
        s16 = out_sum; d16 = out_diff;
        one_shot("R7 sh31", 64'h7000_9000_1234_ABCD, 64'h6000_8800_4321_DCBA,
                 64'h7FFF_7FFF_8000_2222, 5'd31);
        check("R7 sum same as 16",  out_sum,  s16);
        check("R7 diff same as 16", out_diff, d16);
    endtask

    task automatic t_wrap;
        one_shot("R8 wrap", {4{16'h8000}}, {4{16'h8000}}, {4{16'h8000}}, 5'd14);
        check("R8 literal", out_sum, 64'd0);
        one_shot("R8 wrap sh0", {4{16'h7FFF}}, {4{16'h8001}}, {4{16'h7FFF}}, 5'd0);
    endtask

    task automatic t_stream;
        logic [63:0] va[6], vb[6], vc[6];
        logic [4:0]  vs[6];
        for (int k = 0; k < 6; k++) begin
            va[k] = 64'h1357_9BDF_0246_8ACE * 64'(k + 1);
            vb[k] = 64'hFEDC_BA98_7654_3210 ^ 64'(k * 977);
            vc[k] = 64'h2D41_D2BF_3B21_0C7C + 64'(k * 31);
            vs[k] = 5'(k * 3);
        end
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check("R9 stream valid", 64'(out_valid), 64'd1);
                check("R9 stream sum",  out_sum,  ref_word(va[k-2], vb[k-2], vc[k-2], vs[k-2], 1'b0));
                check("R9 stream diff", out_diff, ref_word(va[k-2], vb[k-2], vc[k-2], vs[k-2], 1'b1));
            end
            if (k < 6) begin
                in_a = va[k]; in_b = vb[k]; in_coef = vc[k]; in_shift = vs[k]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R9 stream end", 64'(out_valid), 64'd0);
    endtask

    task automatic t_hold;
        logic [63:0] s0, d0;
        one_shot("R11 setup", 64'h0AAA_0BBB_0CCC_0DDD, 64'h0111_0222_0333_0444,
                 {4{16'h4000}}, 5'd14);
        s0 = out_sum; d0 = out_diff;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_a = 64'(k * 12345); in_b = ~in_a; in_coef = {4{16'h7FFF}}; in_shift = 5'(k);
        end
        @(negedge clk);
        check("R11 hold sum",  out_sum,  s0);
        check("R11 hold diff", out_diff, d0);
        check("R11 no valid",  64'(out_valid), 64'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_lanes();
                t_precision();
                t_s14();
                t_sh0();
                t_clamp();
                t_wrap();
                t_stream();
                t_hold();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog R9 actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule